// File: doc/BRIEF.md
# PWM Output Channel with Staged Duty Update

This block is a single pulse-width-modulated output channel that rides on a time base shared by many channels. Several prescaler units elsewhere in the chip each present a cycle count and a tick strobe. The channel picks one of them, compares the selected count against its own 16-bit duty value on every tick, and drives a pad. The pad is shown as an output-enable and data pair, so it can work either push-pull or open-drain.

Software programs the channel through a byte-wide register window. The duty value is split over two byte registers. The high byte is held back in a staging register and only joins the low byte when the low byte is written. A committed duty value takes effect at the next start of a PWM cycle, so a running cycle is never cut short. A control byte selects inverted polarity, open-drain drive and a clock gate. The gate freezes the channel at its inactive level while register writes still land.

Top module: `pwm_chan`

## Requirements
- R1: After reset the committed duty, staged high byte, control byte and prescaler select are all zero. The pad is driven (`pad_oe`=1) at low level (`pad_do`=0).
- R2: A write to offset 0x01 only loads a staging byte. Offset 0x01 reads back the committed high byte, and neither that readback nor the output changes. A write to offset 0x00 commits {staged byte, written byte} as the 16-bit duty.
- R3: On a selected tick whose count is 0, the committed duty is copied into the effective duty. At no other time does the effective duty change, so a duty committed mid-cycle has no effect until the next cycle start.
- R4: On each selected tick of an ungated channel, the internal active state is set to (count < effective duty). The new duty is used when the count is 0. The state changes on the clock edge that samples the tick and holds between ticks.
- R5: A duty of 0 keeps the output inactive for the whole cycle, including count 0.
- R6: A duty at or above the cycle length (CT+1, where the count runs 0..CT) keeps the output active for the whole cycle.
- R7: Control bit 0 (offset 0x04) inverts polarity. The pad level equals active XOR bit 0, so with inversion the active level is low.
- R8: Control bit 1 gates the channel. While it is set, the active state is forced inactive on every clock, ticks are ignored and the effective duty is kept. Register writes are still accepted.
- R9: Control bit 2 selects open-drain drive: `pad_oe` = NOT level and `pad_do` = 0. With bit 2 clear, the drive is push-pull: `pad_oe` = 1 and `pad_do` = level.
- R10: Bits [1:0] at offset 0x05 select which prescaler's count and tick the channel uses. Count lane i is `prs_cnt[i*CNT_W +: CNT_W]` and tick i is `prs_tick[i]`. Ticks on other prescalers have no effect.
- R11: `reg_rdata` combinationally returns the register at `reg_addr`: 0x00 the committed low byte, 0x01 the committed high byte, 0x04 {5'b0, open-drain, gate, invert}, and 0x05 {6'b0, select}. Unused bits and all other offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe, one byte per cycle |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| prs_cnt | input | NUM_PRS*CNT_W | Cycle counts of all shared prescalers |
| prs_tick | input | NUM_PRS | Tick strobes of all shared prescalers |
| pad_oe | output | 1 | Pad output enable |
| pad_do | output | 1 | Pad output data |

## Verification
The compare is driven by four prescalers with cycle lengths of 10, 5, 16 and 3 counts. Their ticks arrive on sparse random clocks, so holding between ticks is told apart from free-running comparison.

Directed runs cover several duty values:
- duty 0 and a duty far above the cycle length, which separate the two saturated ends from an off-by-one compare;
- a duty committed at count 4, which separates cycle-start loading from immediate loading;
- a staged high byte, which separates commit-on-low-write from direct high-byte writes.

A random phase mixes writes to every offset, including gating and prescaler switches mid-cycle, against an independent bench model of committed, staged and effective duty.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  localparam int ADDR_W = 3;
  localparam int BYTE_W = 8;
  localparam int DUTY_W = 2 * BYTE_W;
  localparam int PSEL_W = 2;

  localparam logic [ADDR_W-1:0] ADR_DUTY_LO = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_DUTY_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_PSEL    = 3'd5;

  typedef struct packed {
    logic od;
    logic gate;
    logic inv;
  } ctrl_t;

endpackage

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_chan_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [DUTY_W-1:0] duty_cmt,
  output logic [BYTE_W-1:0] duty_hold,
  output ctrl_t             ctrl,
  output logic [PSEL_W-1:0] psel,
  output logic [BYTE_W-1:0] rdata
);

  logic              we_lo, we_hi, we_ctrl, we_psel;
  logic [DUTY_W-1:0] duty_cmt_d;
  logic [BYTE_W-1:0] duty_hold_d;
  ctrl_t             ctrl_d;
  logic [PSEL_W-1:0] psel_d;

  // write decode
  always_comb begin
    we_lo   = wr && (addr == ADR_DUTY_LO);
    we_hi   = wr && (addr == ADR_DUTY_HI);
    we_ctrl = wr && (addr == ADR_CTRL);
    we_psel = wr && (addr == ADR_PSEL);
  end

  // next-state values
  always_comb begin
    duty_hold_d = wdata;
    duty_cmt_d  = {duty_hold, wdata};
    ctrl_d      = ctrl_t'(wdata[2:0]);
    psel_d      = wdata[PSEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_hold <= '0;
    end else if (we_hi) begin
      duty_hold <= duty_hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_cmt <= '0;
    end else if (we_lo) begin
      duty_cmt <= duty_cmt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (we_ctrl) begin
      ctrl <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel <= '0;
    end else if (we_psel) begin
      psel <= psel_d;
    end
  end

  // readback mux
  always_comb begin
    rdata = '0;
    case (addr)
      ADR_DUTY_LO: rdata = duty_cmt[BYTE_W-1:0];
      ADR_DUTY_HI: rdata = duty_cmt[DUTY_W-1:BYTE_W];
      ADR_CTRL:    rdata = {{(BYTE_W-3){1'b0}}, ctrl};
      ADR_PSEL:    rdata = {{(BYTE_W-PSEL_W){1'b0}}, psel};
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/pwm_chan_tbsel.sv
module pwm_chan_tbsel
  import pwm_chan_pkg::*;
#(
  parameter int NUM_PRS = 4,
  parameter int CNT_W   = 10
) (
  input  logic [NUM_PRS*CNT_W-1:0] cnt_bus,
  input  logic [NUM_PRS-1:0]       tick_bus,
  input  logic [PSEL_W-1:0]        psel,
  output logic [CNT_W-1:0]         cnt,
  output logic                     tick
);

  localparam int LANES = 1 << PSEL_W;

  logic [CNT_W-1:0] cnt_lane  [LANES];
  logic             tick_lane [LANES];

  // lanes beyond the number of prescalers read as idle
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < NUM_PRS) begin : g_used
      assign cnt_lane[i]  = cnt_bus[i*CNT_W +: CNT_W];
      assign tick_lane[i] = tick_bus[i];
    end else begin : g_idle
      assign cnt_lane[i]  = '0;
      assign tick_lane[i] = 1'b0;
    end
  end

  always_comb begin
    cnt  = cnt_lane[psel];
    tick = tick_lane[psel];
  end

endmodule

// File: rtl/pwm_chan_cmp.sv
module pwm_chan_cmp
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              gate,
  input  logic [DUTY_W-1:0] duty_cmt,
  output logic [DUTY_W-1:0] eff_q,
  output logic              act_q
);

  localparam int CMP_W = (CNT_W > DUTY_W) ? CNT_W : DUTY_W;

  logic [CMP_W-1:0]  cnt_x;
  logic [CMP_W-1:0]  eff_x;
  logic              start;
  logic              eff_en;
  logic              act_en;
  logic [DUTY_W-1:0] eff_d;
  logic              act_d;

  assign cnt_x = CMP_W'(cnt);
  assign eff_x = CMP_W'(eff_q);

  always_comb begin
    start  = tick && (cnt == '0);
    eff_en = start && !gate;
    act_en = gate || tick;
    eff_d  = duty_cmt;
    if (gate) begin
      act_d = 1'b0;
    end else if (start) begin
      act_d = (duty_cmt != '0);
    end else begin
      act_d = (cnt_x < eff_x);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q <= '0;
    end else if (eff_en) begin
      eff_q <= eff_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end

endmodule

// File: rtl/pwm_chan_pad.sv
module pwm_chan_pad (
  input  logic act,
  input  logic inv,
  input  logic od,
  output logic oe,
  output logic dout
);

  logic level;

  always_comb begin
    level = act ^ inv;
    if (od) begin
      oe   = ~level;
      dout = 1'b0;
    end else begin
      oe   = 1'b1;
      dout = level;
    end
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int NUM_PRS = 4,
  parameter int CNT_W   = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [2:0]               reg_addr,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  input  logic [NUM_PRS*CNT_W-1:0] prs_cnt,
  input  logic [NUM_PRS-1:0]       prs_tick,
  output logic                     pad_oe,
  output logic                     pad_do
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [DUTY_W-1:0] duty_cmt;
  logic [BYTE_W-1:0] duty_hold;
  ctrl_t             ctrl_q;
  logic [PSEL_W-1:0] psel_q;
  logic [CNT_W-1:0]  sel_cnt;
  logic              sel_tick;
  logic [DUTY_W-1:0] eff_q;
  logic              act_q;

  // reset asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  pwm_chan_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .duty_cmt  (duty_cmt),
    .duty_hold (duty_hold),
    .ctrl      (ctrl_q),
    .psel      (psel_q),
    .rdata     (reg_rdata)
  );

  pwm_chan_tbsel #(
    .NUM_PRS (NUM_PRS),
    .CNT_W   (CNT_W)
  ) u_tbsel (
    .cnt_bus  (prs_cnt),
    .tick_bus (prs_tick),
    .psel     (psel_q),
    .cnt      (sel_cnt),
    .tick     (sel_tick)
  );

  pwm_chan_cmp #(
    .CNT_W (CNT_W)
  ) u_cmp (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (sel_tick),
    .cnt      (sel_cnt),
    .gate     (ctrl_q.gate),
    .duty_cmt (duty_cmt),
    .eff_q    (eff_q),
    .act_q    (act_q)
  );

  pwm_chan_pad u_pad (
    .act  (act_q),
    .inv  (ctrl_q.inv),
    .od   (ctrl_q.od),
    .oe   (pad_oe),
    .dout (pad_do)
  );

endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wdata,
  input logic [DUTY_W-1:0] duty_cmt,
  input logic [BYTE_W-1:0] duty_hold,
  input logic [DUTY_W-1:0] eff_q,
  input logic              act_q,
  input logic              gate,
  input logic              od,
  input logic              sel_tick,
  input logic [CNT_W-1:0]  sel_cnt,
  input logic              pad_oe,
  input logic              pad_do
);

  AST_HI_STAGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADR_DUTY_HI) |=> $stable(duty_cmt)); // R2

  AST_LO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADR_DUTY_LO) |=> duty_cmt == {$past(duty_hold), $past(wdata)}); // R2

  AST_EFF_AT_START_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_tick && sel_cnt == '0 && !gate) |=> $stable(eff_q)); // R3

  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_cmt == '0 && eff_q == '0) |=> !act_q); // R5

  AST_GATE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    gate |=> !act_q); // R8

  AST_OD_NO_HIGH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (od && pad_oe) |-> !pad_do); // R9

  AST_PP_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !od |-> pad_oe); // R9

endmodule

bind pwm_chan pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .wr        (reg_wr),
  .addr      (reg_addr),
  .wdata     (reg_wdata),
  .duty_cmt  (duty_cmt),
  .duty_hold (duty_hold),
  .eff_q     (eff_q),
  .act_q     (act_q),
  .gate      (ctrl_q.gate),
  .od        (ctrl_q.od),
  .sel_tick  (sel_tick),
  .sel_cnt   (sel_cnt),
  .pad_oe    (pad_oe),
  .pad_do    (pad_do)
);

// File: tb/pwm_chan_tb.sv
`timescale 1ns/1ps
module pwm_chan_tb;

  localparam int NP = 4;
  localparam int CW = 10;

  logic          clk;
  logic          rst_n;
  logic          reg_wr;
  logic [2:0]    reg_addr;
  logic [7:0]    reg_wdata;
  logic [7:0]    reg_rdata;
  logic [NP*CW-1:0] prs_cnt;
  logic [NP-1:0] prs_tick;
  logic          pad_oe;
  logic          pad_do;

  pwm_chan #(.NUM_PRS(NP), .CNT_W(CW)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .prs_cnt   (prs_cnt),
    .prs_tick  (prs_tick),
    .pad_oe    (pad_oe),
    .pad_do    (pad_do)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk;
  int n_fail;
  int ct  [NP];
  int ctr [NP];

  // bench model of the channel
  logic [15:0] m_cmt, m_eff;
  logic [7:0]  m_hold;
  logic [2:0]  m_ctrl;
  logic [1:0]  m_sel;
  logic        m_act;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [1:0] exp_pad();
    logic lvl;
    lvl = m_act ^ m_ctrl[0];
    if (m_ctrl[2]) return {~lvl, 1'b0};
    return {1'b1, lvl};
  endfunction

  task automatic step(input string tag, input bit wr, input logic [2:0] a,
                      input logic [7:0] d, input logic [NP-1:0] tm);
    logic tk;
    int c;
    reg_wr    = wr;
    reg_addr  = a;
    reg_wdata = d;
    for (int p = 0; p < NP; p++) prs_cnt[p*CW +: CW] = CW'(ctr[p]);
    prs_tick = tm;
    @(posedge clk);
    tk = tm[m_sel];
    c  = ctr[m_sel];
    if (m_ctrl[1]) begin
      m_act = 1'b0;
    end else if (tk) begin
      if (c == 0) begin
        m_eff = m_cmt;
        m_act = (m_cmt != 0);
      end else begin
        m_act = (c < m_eff);
      end
    end
    if (wr) begin
      case (a)
        3'd0: m_cmt  = {m_hold, d};
        3'd1: m_hold = d;
        3'd4: m_ctrl = d[2:0];
        3'd5: m_sel  = d[1:0];
        default: ;
      endcase
    end
    for (int p = 0; p < NP; p++)
      if (tm[p]) ctr[p] = (ctr[p] == ct[p]) ? 0 : ctr[p] + 1;
    @(negedge clk);
    reg_wr   = 1'b0;
    prs_tick = '0;
    check(tag, {14'd0, pad_oe, pad_do}, {14'd0, exp_pad()});
  endtask

  task automatic run(input string tag, input int n, input logic [NP-1:0] tm);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 3'd0, 8'd0, tm);
  endtask

  task automatic wr_reg(input string tag, input logic [2:0] a, input logic [7:0] d);
    step(tag, 1'b1, a, d, '0);
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    check(tag, {8'd0, reg_rdata}, {8'd0, exp});
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    n_chk = 0; n_fail = 0;
    ct[0] = 9; ct[1] = 4; ct[2] = 15; ct[3] = 2;
    for (int p = 0; p < NP; p++) ctr[p] = 0;
    m_cmt = '0; m_eff = '0; m_hold = '0; m_ctrl = '0; m_sel = '0; m_act = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    prs_cnt = '0; prs_tick = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 pad", {14'd0, pad_oe, pad_do}, 16'h0002);
    rd_chk("R1 lo", 3'd0, 8'h00);
    rd_chk("R1 hi", 3'd1, 8'h00);
    rd_chk("R1 ctrl", 3'd4, 8'h00);
    rd_chk("R1 sel", 3'd5, 8'h00);

    // R5 zero duty over full cycles
    run("R5", 22, 4'b0001);

    // R2 staging of the high byte
    wr_reg("R2", 3'd1, 8'hA5);
    rd_chk("R2 hi staged", 3'd1, 8'h00);
    rd_chk("R2 lo untouched", 3'd0, 8'h00);
    run("R2", 12, 4'b0001);
    wr_reg("R2", 3'd0, 8'h03);
    rd_chk("R2 lo commit", 3'd0, 8'h03);
    rd_chk("R2 hi commit", 3'd1, 8'hA5);

    // R6 duty far above cycle length
    run("R6", 25, 4'b0001);

    // R4 ordinary duty
    wr_reg("R4", 3'd1, 8'h00);
    wr_reg("R4", 3'd0, 8'h03);
    run("R4", 22, 4'b0001);
    run("R4", 6, 4'b0000);

    // R3 commit mid-cycle, applied at next start only
    while (ctr[0] != 4) step("R3", 1'b0, 3'd0, 8'd0, 4'b0001);
    wr_reg("R3", 3'd0, 8'h08);
    run("R3", 20, 4'b0001);

    // R7 inversion, R9 open-drain
    wr_reg("R7", 3'd4, 8'h01);
    run("R7", 12, 4'b0001);
    wr_reg("R9", 3'd4, 8'h04);
    run("R9", 12, 4'b0001);
    wr_reg("R9", 3'd4, 8'h05);
    run("R9", 12, 4'b0001);

    // R8 gating
    wr_reg("R8", 3'd4, 8'h02);
    run("R8", 12, 4'b0001);
    wr_reg("R8", 3'd1, 8'h00);
    wr_reg("R8", 3'd0, 8'h02);
    rd_chk("R8 write while gated", 3'd0, 8'h02);
    run("R8", 5, 4'b0001);
    wr_reg("R8", 3'd4, 8'h00);
    run("R8", 14, 4'b0001);

    // R10 prescaler select
    wr_reg("R10", 3'd5, 8'h02);
    run("R10", 20, 4'b0100);
    run("R10", 8, 4'b1011);
    wr_reg("R10", 3'd5, 8'h01);
    run("R10", 15, 4'b1111);

    // R11 readback map
    wr_reg("R11", 3'd4, 8'hFF);
    rd_chk("R11 ctrl", 3'd4, 8'h07);
    wr_reg("R11", 3'd5, 8'hFF);
    rd_chk("R11 sel", 3'd5, 8'h03);
    rd_chk("R11 off2", 3'd2, 8'h00);
    rd_chk("R11 off7", 3'd7, 8'h00);
    wr_reg("R11", 3'd4, 8'h00);
    wr_reg("R11", 3'd5, 8'h00);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit w;
      logic [2:0] a;
      logic [7:0] d;
      int r;
      w = ($urandom_range(0, 7) == 0);
      r = $urandom_range(0, 9);
      if (r <= 2) a = 3'd0;
      else if (r <= 4) a = 3'd1;
      else if (r == 5) a = 3'd4;
      else if (r == 6) a = 3'd5;
      else a = 3'($urandom_range(0, 7));
      case (a)
        3'd0: d = 8'($urandom_range(0, 20));
        3'd1: d = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 255)) : 8'd0;
        3'd4: d = 8'($urandom_range(0, 7)) & (($urandom_range(0, 3) == 0) ? 8'h07 : 8'h05);
        default: d = 8'($urandom_range(0, 255));
      endcase
      step("R4 random", w, a, d, 4'($urandom_range(0, 15)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule